// File: doc/BRIEF.md
# USB Receive Deserializer Front End

This block turns the raw receive signals of an external full-speed or low-speed USB transceiver into a byte stream. It takes the transceiver's differential receive output together with the two single-ended line receivers. An oversampling clock recovers the bit timing. The recovered line levels are NRZI-decoded, and the decoded stream is searched for a programmable start-of-frame pattern. Once the pattern is found, stuffed bits are removed and the payload is packed into bytes, least significant bit first.

A single-ended zero on both line receivers, seen at a bit centre, ends the frame. The block then returns to pattern search. Sync-like data inside a frame therefore never restarts a frame. The block pulses an interrupt output when a frame starts and pulses a byte strobe for each completed byte. It flags a frame that ends on a partial byte, and it flags a run of ones that breaks the stuffing rule. CRC, PID handling and transmission belong to other blocks.

Top module: `usbrx_frontend`

## Requirements
- R1: After reset every pulse output and `frame_active` are low, and the start pattern register holds 8'h80.
- R2: With no rate divide, the block takes one line sample per clock. Each bit lasts four samples. The bit value is taken at the third sample after the most recent level change of `rxd` (sample index 2, counting the change as index 0). Every change re-centres the phase, so a bit shortened by one sample is still recovered correctly.
- R3: NRZI decoding: a bit whose level equals the previous bit's level decodes as 1, and a level change decodes as 0. The reference level after a single-ended zero is the idle level: 1 on `rxd` at full speed, 0 at low speed.
- R4: While searching, the last 8 decoded bits are held with the newest bit in bit 7 and compared with the pattern register. On equality, `pkt_start` pulses for one cycle and `frame_active` rises. A cycle with `cfg_sync_we` high loads `cfg_sync_wdata` into the pattern register.
- R5: While `frame_active` is high, no pattern match is made, so payload bits that equal the pattern do not pulse `pkt_start`.
- R6: Inside a frame, a 0 that follows six consecutive decoded 1s is dropped. The run count starts at zero at the match.
- R7: Each 8 kept bits form one byte, first received bit in bit 0. The byte appears on `byte_data` with a one-cycle `byte_valid` pulse.
- R8: A bit-centre sample with `vp` and `vm` both low ends an active frame. It pulses `eop` and lowers `frame_active`. While searching, such a sample pulses nothing.
- R9: If a frame ends with 1 to 7 kept bits not yet forming a byte, `frame_err` pulses in the same cycle as `eop`.
- R10: A seventh consecutive 1 inside a frame pulses `stuff_err`. No further bytes or pattern matches are produced until the next single-ended zero, which also pulses `eop`.
- R11: With `low_speed` high, the line is sampled once every 8 clocks, so a bit lasts 32 clocks, and decoding is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock (four samples per full-speed bit) |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_speed | input | 1 | 1 selects the low rate (sample every 8 clocks) |
| rxd | input | 1 | Differential receive data from the transceiver |
| vp | input | 1 | Single-ended receiver of the plus line |
| vm | input | 1 | Single-ended receiver of the minus line |
| cfg_sync_we | input | 1 | Write strobe for the start pattern register |
| cfg_sync_wdata | input | 8 | New start pattern value |
| pkt_start | output | 1 | One-cycle pulse on a start pattern match (interrupt) |
| byte_valid | output | 1 | One-cycle pulse, a byte is on byte_data |
| byte_data | output | 8 | Last completed byte |
| eop | output | 1 | One-cycle pulse at the end of an active frame |
| frame_err | output | 1 | One-cycle pulse, frame ended on a partial byte |
| stuff_err | output | 1 | One-cycle pulse, stuffing rule broken |
| frame_active | output | 1 | High from a match until the end of the frame |

## Verification
Several rules are checked by assertions on every cycle. Bit strobes never come back to back. The stuffing run count never passes six. A start pulse, a byte strobe or a stuffing error only occurs with the frame marked active. No start pulse follows a cycle in which the frame was already active. A framing error never appears without an end-of-frame pulse, and the four event pulses are mutually exclusive. The correctness of the recovered bytes is shown only by the bench's frames. So are phase tracking under shortened bits, NRZI decoding at both rates, unstuffing, pattern reprogramming, and the partial-byte and stuffing-violation cases.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_DATA  = 2'd1,
      ST_ABORT = 2'd2
   } rx_state_t;
endpackage

// File: rtl/usbrx_bit_recover.sv
// Samples the line through a synchronizer, divides the sample rate for the
// slow mode and emits one strobe per bit at the bit centre.
module usbrx_bit_recover #(
   parameter int OVS         = 4,
   parameter int LS_DIV      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic low_speed,
   input  logic rxd,
   input  logic vp,
   input  logic vm,
   output logic strobe_o,
   output logic level_o,
   output logic se0_o
);
   localparam int PH_W = (OVS > 1) ? $clog2(OVS) : 1;
   localparam logic [PH_W-1:0] PH_LAST   = PH_W'(OVS - 1);
   localparam logic [PH_W-1:0] PH_CENTER = PH_W'(OVS / 2);

   if (OVS < 3) begin : g_bad_ovs
      $error("usbrx_bit_recover: OVS must be at least 3");
   end
   if (LS_DIV < 1) begin : g_bad_div
      $error("usbrx_bit_recover: LS_DIV must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("usbrx_bit_recover: SYNC_STAGES must be at least 1");
   end

   // input synchronizer: {rxd, vp, vm}
   logic [2:0] sync_q [SYNC_STAGES];
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 3'b110;
      end else begin
         sync_q[0] <= {rxd, vp, vm};
         for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      end
   end
   logic cur_rxd, cur_se0;
   assign cur_rxd = sync_q[SYNC_STAGES-1][2];
   assign cur_se0 = ~sync_q[SYNC_STAGES-1][1] & ~sync_q[SYNC_STAGES-1][0];

   // sample enable
   logic ce;
   if (LS_DIV == 1) begin : g_nodiv
      logic unused_ls;
      assign unused_ls = low_speed;
      assign ce = 1'b1;
   end else begin : g_div
      localparam int DIV_W = $clog2(LS_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(LS_DIV - 1);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                div_q <= '0;
         else if (div_q == DIV_LAST) div_q <= '0;
         else                       div_q <= div_q + 1'b1;
      end
      assign ce = !low_speed || (div_q == '0);
   end

   // phase tracking
   logic [PH_W-1:0] ph_q;
   logic            last_q;
   logic            edge_seen;
   assign edge_seen = (cur_rxd != last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= '0;
         last_q   <= 1'b1;
         strobe_o <= 1'b0;
         level_o  <= 1'b1;
         se0_o    <= 1'b0;
      end else begin
         strobe_o <= 1'b0;
         if (ce) begin
            last_q <= cur_rxd;
            if (edge_seen)             ph_q <= PH_W'(1);
            else if (ph_q == PH_LAST)  ph_q <= '0;
            else                       ph_q <= ph_q + 1'b1;
            if (!edge_seen && ph_q == PH_CENTER) begin
               strobe_o <= 1'b1;
               level_o  <= cur_rxd;
               se0_o    <= cur_se0;
            end
         end
      end
   end

   // R2: one centre sample per bit, never two strobes in a row
   assert_strobe_gap_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |=> !strobe_o);
endmodule

// File: rtl/usbrx_nrzi_decode.sv
// Turns centre samples into decoded bits and end-of-packet strobes.
module usbrx_nrzi_decode (
   input  logic clk,
   input  logic rst_n,
   input  logic low_speed,
   input  logic strobe_i,
   input  logic level_i,
   input  logic se0_i,
   output logic bit_stb_o,
   output logic bit_o,
   output logic se0_stb_o
);
   logic prev_q;

   assign bit_stb_o = strobe_i & ~se0_i;
   assign se0_stb_o = strobe_i & se0_i;
   assign bit_o     = (level_i == prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prev_q <= 1'b1;
      else if (strobe_i) prev_q <= se0_i ? ~low_speed : level_i;
   end
endmodule

// File: rtl/usbrx_deframer.sv
// Start pattern search, unstuffing, byte packing and frame end handling.
module usbrx_deframer
   import usbrx_pkg::*;
#(
   parameter int SYNC_W  = 8,
   parameter int DATA_W  = 8,
   parameter int RUN_MAX = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb_i,
   input  logic              bit_i,
   input  logic              se0_stb_i,
   input  logic [SYNC_W-1:0] pattern_i,
   output logic              pkt_start_o,
   output logic              byte_valid_o,
   output logic [DATA_W-1:0] byte_o,
   output logic              eop_o,
   output logic              frame_err_o,
   output logic              stuff_err_o,
   output logic              active_o
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
   localparam int RUN_W = $clog2(RUN_MAX + 1);
   localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(RUN_MAX);

   if (SYNC_W < 2) begin : g_bad_sync
      $error("usbrx_deframer: SYNC_W must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("usbrx_deframer: DATA_W must be at least 2");
   end
   if (RUN_MAX < 1) begin : g_bad_run
      $error("usbrx_deframer: RUN_MAX must be at least 1");
   end

   rx_state_t          state_q;
   logic [SYNC_W-1:0]  hunt_q;
   logic [DATA_W-1:0]  data_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [RUN_W-1:0]   ones_q;

   logic [SYNC_W-1:0]  hunt_next;
   logic [DATA_W-1:0]  data_next;
   assign hunt_next = {bit_i, hunt_q[SYNC_W-1:1]};
   assign data_next = {bit_i, data_q[DATA_W-1:1]};
   assign active_o  = (state_q != ST_HUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_HUNT;
         hunt_q       <= '1;
         data_q       <= '0;
         cnt_q        <= '0;
         ones_q       <= '0;
         pkt_start_o  <= 1'b0;
         byte_valid_o <= 1'b0;
         byte_o       <= '0;
         eop_o        <= 1'b0;
         frame_err_o  <= 1'b0;
         stuff_err_o  <= 1'b0;
      end else begin
         pkt_start_o  <= 1'b0;
         byte_valid_o <= 1'b0;
         eop_o        <= 1'b0;
         frame_err_o  <= 1'b0;
         stuff_err_o  <= 1'b0;
         if (se0_stb_i) begin
            if (state_q != ST_HUNT) begin
               eop_o       <= 1'b1;
               frame_err_o <= (state_q == ST_DATA) && (cnt_q != '0);
            end
            state_q <= ST_HUNT;
            hunt_q  <= '1;
         end else if (bit_stb_i) begin
            case (state_q)
               ST_HUNT: begin
                  hunt_q <= hunt_next;
                  if (hunt_next == pattern_i) begin
                     state_q     <= ST_DATA;
                     pkt_start_o <= 1'b1;
                     ones_q      <= '0;
                     cnt_q       <= '0;
                  end
               end
               ST_DATA: begin
                  if (ones_q == RUN_LIM) begin
                     if (bit_i) begin
                        stuff_err_o <= 1'b1;
                        state_q     <= ST_ABORT;
                     end
                     ones_q <= '0;
                  end else begin
                     data_q <= data_next;
                     ones_q <= bit_i ? ones_q + 1'b1 : '0;
                     if (cnt_q == CNT_LAST) begin
                        cnt_q        <= '0;
                        byte_valid_o <= 1'b1;
                        byte_o       <= data_next;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assert_run_bound_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      ones_q <= RUN_LIM);
   assert_start_marks_frame_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start_o |-> active_o);
   assert_no_rematch_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      active_o |=> !pkt_start_o);
   assert_byte_in_frame_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid_o |-> active_o);
   assert_ferr_with_eop_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |-> eop_o);
   assert_stuff_in_frame_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      stuff_err_o |-> active_o);
   assert_events_exclusive_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pkt_start_o, byte_valid_o, eop_o, stuff_err_o}));
endmodule

// File: rtl/usbrx_frontend.sv
module usbrx_frontend #(
   parameter int               OVS         = 4,
   parameter int               LS_DIV      = 8,
   parameter int               SYNC_STAGES = 2,
   parameter int               SYNC_W      = 8,
   parameter int               DATA_W      = 8,
   parameter int               RUN_MAX     = 6,
   parameter logic [SYNC_W-1:0] SYNC_RESET = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              low_speed,
   input  logic              rxd,
   input  logic              vp,
   input  logic              vm,
   input  logic              cfg_sync_we,
   input  logic [SYNC_W-1:0] cfg_sync_wdata,
   output logic              pkt_start,
   output logic              byte_valid,
   output logic [DATA_W-1:0] byte_data,
   output logic              eop,
   output logic              frame_err,
   output logic              stuff_err,
   output logic              frame_active
);
   logic [SYNC_W-1:0] pattern_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pattern_q <= SYNC_RESET;
      else if (cfg_sync_we) pattern_q <= cfg_sync_wdata;
   end

   logic smp_stb, smp_level, smp_se0;
   logic dec_stb, dec_bit, dec_se0;

   usbrx_bit_recover #(
      .OVS(OVS), .LS_DIV(LS_DIV), .SYNC_STAGES(SYNC_STAGES)
   ) u_recover (
      .clk(clk), .rst_n(rst_n), .low_speed(low_speed),
      .rxd(rxd), .vp(vp), .vm(vm),
      .strobe_o(smp_stb), .level_o(smp_level), .se0_o(smp_se0)
   );

   usbrx_nrzi_decode u_nrzi (
      .clk(clk), .rst_n(rst_n), .low_speed(low_speed),
      .strobe_i(smp_stb), .level_i(smp_level), .se0_i(smp_se0),
      .bit_stb_o(dec_stb), .bit_o(dec_bit), .se0_stb_o(dec_se0)
   );

   usbrx_deframer #(
      .SYNC_W(SYNC_W), .DATA_W(DATA_W), .RUN_MAX(RUN_MAX)
   ) u_deframer (
      .clk(clk), .rst_n(rst_n),
      .bit_stb_i(dec_stb), .bit_i(dec_bit), .se0_stb_i(dec_se0),
      .pattern_i(pattern_q),
      .pkt_start_o(pkt_start), .byte_valid_o(byte_valid), .byte_o(byte_data),
      .eop_o(eop), .frame_err_o(frame_err), .stuff_err_o(stuff_err),
      .active_o(frame_active)
   );
endmodule

// File: tb/usbrx_frontend_test.sv
`timescale 1ns/1ps
module usbrx_frontend_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       low_speed = 1'b0;
   logic       rxd = 1'b1, vp = 1'b1, vm = 1'b0;
   logic       cfg_sync_we = 1'b0;
   logic [7:0] cfg_sync_wdata = 8'h00;
   logic       pkt_start, byte_valid, eop, frame_err, stuff_err, frame_active;
   logic [7:0] byte_data;

   always #5 clk = ~clk;

   usbrx_frontend uut (
      .clk(clk), .rst_n(rst_n), .low_speed(low_speed),
      .rxd(rxd), .vp(vp), .vm(vm),
      .cfg_sync_we(cfg_sync_we), .cfg_sync_wdata(cfg_sync_wdata),
      .pkt_start(pkt_start), .byte_valid(byte_valid), .byte_data(byte_data),
      .eop(eop), .frame_err(frame_err), .stuff_err(stuff_err),
      .frame_active(frame_active)
   );

   int n_vec = 0, n_bad = 0;
   int irq_cnt = 0, eop_cnt = 0, ferr_cnt = 0, serr_cnt = 0;
   logic [7:0] exp_q[$];
   bit   dq[$];
   int   run = 0;
   bit   done = 0;

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor, sampled away from the rising edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (pkt_start) irq_cnt++;
         if (eop)       eop_cnt++;
         if (frame_err) ferr_cnt++;
         if (stuff_err) serr_cnt++;
         if (byte_valid) begin
            if (exp_q.size() == 0) begin
               check("R7 unexpected byte", int'(byte_data), -1);
            end else begin
               check("R7 byte value", int'(byte_data), int'(exp_q.pop_front()));
            end
         end
      end
   end

   task automatic add_sync(input logic [7:0] p);
      for (int i = 0; i < 8; i++) dq.push_back(p[i]);
      run = 0;
   endtask

   task automatic add_bits(input logic [7:0] b, input int n, input bit expect_b);
      for (int i = 0; i < n; i++) begin
         dq.push_back(b[i]);
         if (b[i]) begin
            run++;
            if (run == 6) begin dq.push_back(1'b0); run = 0; end
         end else run = 0;
      end
      if (expect_b) exp_q.push_back(b);
   endtask

   task automatic add_raw(input bit v, input int n);
      for (int i = 0; i < n; i++) dq.push_back(v);
      run = 0;
   endtask

   task automatic drive_line(input logic lvl, input bit se0, input int clocks);
      rxd = lvl;
      vp  = se0 ? 1'b0 : lvl;
      vm  = se0 ? 1'b0 : ~lvl;
      repeat (clocks) @(negedge clk);
   endtask

   task automatic send_frame(input bit jit);
      int   div;
      logic idle, cur;
      int   hold;
      div  = low_speed ? 8 : 1;
      idle = ~low_speed;
      cur  = idle;
      drive_line(idle, 0, 4 * 4 * div);
      for (int i = 0; i < dq.size(); i++) begin
         if (dq[i] == 1'b0) cur = ~cur;
         hold = 4 * div;
         if (jit && (i + 1 < dq.size()) && dq[i+1] == 1'b0) hold -= div;
         drive_line(cur, 0, hold);
      end
      drive_line(idle, 1, 2 * 4 * div);
      drive_line(idle, 0, 6 * 4 * div);
      dq.delete();
   endtask

   task automatic frame_result(input string tag, input int irq0, input int eop0,
                               input int ferr0, input int serr0,
                               input int d_irq, input int d_eop, input int d_ferr,
                               input int d_serr);
      check({tag, " start pulses"}, irq_cnt - irq0, d_irq);
      check({tag, " eop pulses"}, eop_cnt - eop0, d_eop);
      check({tag, " frame errors"}, ferr_cnt - ferr0, d_ferr);
      check({tag, " stuff errors"}, serr_cnt - serr0, d_serr);
      check({tag, " bytes missing"}, exp_q.size(), 0);
      check({tag, " active after end"}, int'(frame_active), 0);
      exp_q.delete();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL all: watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : stim
      int i0, e0, f0, s0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 pkt_start", int'(pkt_start), 0);
      check("R1 byte_valid", int'(byte_valid), 0);
      check("R1 eop", int'(eop), 0);
      check("R1 frame_active", int'(frame_active), 0);

      // R2 R3 R4 R6 R7 R8: every byte value, full speed, reset pattern 8'h80
      i0 = irq_cnt; e0 = eop_cnt; f0 = ferr_cnt; s0 = serr_cnt;
      add_sync(8'h80);
      for (int b = 0; b < 256; b++) add_bits(8'(b), 8, 1);
      send_frame(0);
      frame_result("R7 sweep", i0, e0, f0, s0, 1, 1, 0, 0);

      // R2: shortened bits before every level change
      i0 = irq_cnt; e0 = eop_cnt; f0 = ferr_cnt; s0 = serr_cnt;
      add_sync(8'h80);
      for (int b = 0; b < 64; b++) add_bits(8'((b * 37 + 11) % 256), 8, 1);
      for (int b = 0; b < 4; b++) add_bits(8'hFF, 8, 1);
      send_frame(1);
      frame_result("R2 jitter", i0, e0, f0, s0, 1, 1, 0, 0);

      // R5: payload carrying the start pattern itself
      i0 = irq_cnt; e0 = eop_cnt; f0 = ferr_cnt; s0 = serr_cnt;
      add_sync(8'h80);
      add_bits(8'h80, 8, 1); add_bits(8'h00, 8, 1);
      add_bits(8'h80, 8, 1); add_bits(8'h80, 8, 1);
      send_frame(0);
      frame_result("R5 embedded pattern", i0, e0, f0, s0, 1, 1, 0, 0);

      // R9: one byte plus three bits
      i0 = irq_cnt; e0 = eop_cnt; f0 = ferr_cnt; s0 = serr_cnt;
      add_sync(8'h80);
      add_bits(8'hA5, 8, 1);
      add_bits(8'b010, 3, 0);
      send_frame(0);
      frame_result("R9 partial byte", i0, e0, f0, s0, 1, 1, 1, 0);

      // R10: seven ones, then a full pattern and a byte that must be ignored
      i0 = irq_cnt; e0 = eop_cnt; f0 = ferr_cnt; s0 = serr_cnt;
      add_sync(8'h80);
      add_bits(8'h12, 8, 1);
      add_raw(1'b1, 7);
      add_sync(8'h80);
      add_bits(8'h34, 8, 0);
      send_frame(0);
      frame_result("R10 stuffing violation", i0, e0, f0, s0, 1, 1, 0, 1);

      // R4: reprogrammed pattern; the old pattern no longer starts a frame
      @(negedge clk);
      cfg_sync_we = 1'b1; cfg_sync_wdata = 8'hC0;
      @(negedge clk);
      cfg_sync_we = 1'b0;
      i0 = irq_cnt; e0 = eop_cnt; f0 = ferr_cnt; s0 = serr_cnt;
      add_sync(8'h80);
      add_bits(8'hAA, 8, 0); add_bits(8'hAA, 8, 0);
      send_frame(0);
      frame_result("R4 old pattern, R8 idle end", i0, e0, f0, s0, 0, 0, 0, 0);
      i0 = irq_cnt; e0 = eop_cnt; f0 = ferr_cnt; s0 = serr_cnt;
      add_sync(8'hC0);
      add_bits(8'h3C, 8, 1); add_bits(8'hE7, 8, 1);
      send_frame(0);
      frame_result("R4 new pattern", i0, e0, f0, s0, 1, 1, 0, 0);
      @(negedge clk);
      cfg_sync_we = 1'b1; cfg_sync_wdata = 8'h80;
      @(negedge clk);
      cfg_sync_we = 1'b0;

      // R11 R3: low speed, idle level 0 on rxd, with shortened bits
      low_speed = 1'b1;
      drive_line(1'b0, 0, 64);
      i0 = irq_cnt; e0 = eop_cnt; f0 = ferr_cnt; s0 = serr_cnt;
      add_sync(8'h80);
      for (int b = 0; b < 24; b++) add_bits(8'((b * 73 + 5) % 256), 8, 1);
      add_bits(8'hFF, 8, 1); add_bits(8'h7E, 8, 1);
      send_frame(1);
      frame_result("R11 low speed", i0, e0, f0, s0, 1, 1, 0, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule